// File: doc/BRIEF.md
# Parking Bus Arbiter with Broken-Initiator Detection

This block decides which party may drive a shared parallel bus. Requester 0 is the host controller; requesters 1 to NREQ-1 are external initiators. Each requester raises its request line and the arbiter answers with registered, one-hot grant lines. Grants move only while the bus is idle, meaning both the frame and ready indications are low. A priority bit per requester splits them into a high and a low group. Within a group, a rotating pointer gives round-robin service.

When nobody is asking for the bus, the grant is parked according to a mode input. Either the last initiator that actually ran a transaction keeps it, or the host controller receives it. An optional watchdog catches an external initiator that is granted, keeps requesting, and never starts a transaction. Such an initiator is flagged, and its request is ignored until the flag is cleared by a write-one-to-clear pulse. A strap input, captured while reset is held, can switch the whole arbiter off.

Top module: `busarb_top`

## Requirements
- R1: While `rst` is high, `gnt_o` and `ign_o` are all zero. The round-robin pointer restarts so that the first search begins at index 0, and the last bus user is taken to be index 0.
- R2: `arb_off_strap_i` is captured on every clock edge where `rst` is high. If the value held when reset drops is 1, `gnt_o` stays zero until the next reset.
- R3: `gnt_o` is registered and has at most one bit set. It changes only on an edge after a cycle in which `bus_frame_i` and `bus_ready_i` were both 0.
- R4: Whenever the grant passes from one requester to a different one, one cycle with `gnt_o` all zero lies between them.
- R5: A requester whose `prio_i` bit is 1 is always chosen before any requester whose bit is 0.
- R6: Within the chosen group, the search starts at the index after the requester most recently granted by arbitration and wraps upward from there.
- R7: With `park_host_i`=0 and no effective request, the grant goes to, or stays with, the last requester that started a transaction.
- R8: With `park_host_i`=1 and no effective request, the grant goes to index 0.
- R9: A transaction start is a cycle with `bus_frame_i`=1 while a grant is driven; it is credited to the holder. Until it starts, a holder that keeps requesting keeps its grant over idle cycles.
- R10: With `bm_off_i`=0, an external holder (index 1 or above) accumulates 16 consecutive idle cycles that are counted. A cycle counts when the holder is granted, is requesting, and has not yet started. After the 16th such cycle, its `ign_o` bit is set and its request is ignored. `ign_o[0]` is never set.
- R11: With `bm_off_i`=1, no `ign_o` bit becomes set, and flags already set have no effect on arbitration.
- R12: A 1 on `ign_clr_i[i]` clears `ign_o[i]` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NREQ | Request lines, index 0 is the host controller |
| prio_i | input | NREQ | Priority bit per requester, 1 = high group |
| bus_frame_i | input | 1 | Frame indication, high while a transaction is under way |
| bus_ready_i | input | 1 | Ready indication, high while a data phase is active |
| park_host_i | input | 1 | Parking mode: 0 = last user, 1 = host controller |
| bm_off_i | input | 1 | 1 turns broken-initiator detection off |
| arb_off_strap_i | input | 1 | Arbiter disable strap, captured during reset |
| ign_clr_i | input | NREQ | Write-one-to-clear pulses for the ignore flags |
| gnt_o | output | NREQ | One-hot grant lines |
| ign_o | output | NREQ | Ignore flags of broken initiators |

## Verification
The bench aims at the handover cycle. A design that skips the all-zero gap would let two initiators overlap on the bus. It also aims at the boundary of the 16-cycle idle window: a counter that is off by one flags a healthy initiator one cycle early, or lets a broken one hold the bus one cycle longer. It checks parking on the last user against parking on the host. A design that tracks the last grant rather than the last transaction would park on an initiator that never used the bus. Random traffic with a reference model exercises priority groups, pointer rotation and grants frozen while the bus is busy. A wrong pointer update would show up as starvation or as a repeated winner.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

    // Action chosen by the arbitration decision for the next edge
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_GAP   = 2'd1,
        ACT_GRANT = 2'd2,
        ACT_PARK  = 2'd3
    } arb_act_e;

    // Snapshot of the bus state lines
    typedef struct packed {
        logic frame;
        logic ready;
    } bus_obs_t;

    function automatic logic bus_is_idle(bus_obs_t b);
        return !b.frame && !b.ready;
    endfunction

endpackage

// File: rtl/busarb_select.sv
module busarb_select #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    input  logic [N-1:0]  prio_i,
    input  logic [IW-1:0] ptr_i,
    output logic          found_o,
    output logic [IW-1:0] win_o
);
    int  idx;
    logic hi_hit;

    always_comb begin
        found_o = 1'b0;
        win_o   = '0;
        hi_hit  = 1'b0;
        idx     = 0;
        // high group first, rotating from the slot after the pointer
        for (int k = 1; k <= N; k++) begin
            idx = (int'(ptr_i) + k) % N;
            if (!hi_hit && req_i[idx] && prio_i[idx]) begin
                hi_hit  = 1'b1;
                found_o = 1'b1;
                win_o   = IW'(idx);
            end
        end
        // otherwise any requester, same rotation
        if (!hi_hit) begin
            for (int k = 1; k <= N; k++) begin
                idx = (int'(ptr_i) + k) % N;
                if (!found_o && req_i[idx]) begin
                    found_o = 1'b1;
                    win_o   = IW'(idx);
                end
            end
        end
    end
endmodule

// File: rtl/busarb_bmwatch.sv
module busarb_bmwatch #(
    parameter int N     = 4,
    parameter int LIMIT = 16,
    parameter int IW    = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          hv_i,
    input  logic [IW-1:0] idx_i,
    input  logic          hreq_i,
    input  logic          used_i,
    input  logic          idle_i,
    input  logic [N-1:0]  clr_i,
    output logic [N-1:0]  ign_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;
    logic [N-1:0]  ign_q;
    logic [N-1:0]  set_vec;
    logic          counting;
    logic          hit;

    // only external initiators are watched; the host is never flagged
    assign counting = en_i && hv_i && (idx_i != '0) && hreq_i && !used_i && idle_i;
    assign hit      = counting && (cnt_q == CW'(LIMIT - 1));
    assign set_vec  = hit ? ({{(N-1){1'b0}}, 1'b1} << idx_i) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ign_q <= '0;
        end else begin
            cnt_q <= (counting && !hit) ? cnt_q + 1'b1 : '0;
            ign_q <= (ign_q & ~clr_i) | set_vec;
        end
    end

    assign ign_o = ign_q;
endmodule

// File: rtl/busarb_top.sv
module busarb_top
    import busarb_pkg::*;
#(
    parameter int NREQ       = 4,
    parameter int IDLE_LIMIT = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREQ-1:0] req_i,
    input  logic [NREQ-1:0] prio_i,
    input  logic            bus_frame_i,
    input  logic            bus_ready_i,
    input  logic            park_host_i,
    input  logic            bm_off_i,
    input  logic            arb_off_strap_i,
    input  logic [NREQ-1:0] ign_clr_i,
    output logic [NREQ-1:0] gnt_o,
    output logic [NREQ-1:0] ign_o
);
    localparam int IW = $clog2(NREQ);

    logic            off_q;
    logic [NREQ-1:0] gnt_q;
    logic            used_q;
    logic [IW-1:0]   last_q;
    logic [IW-1:0]   ptr_q;

    bus_obs_t        obs;
    logic            idle;
    logic            hv;
    logic [IW-1:0]   hidx;
    logic [NREQ-1:0] eff_req;
    logic [NREQ-1:0] ign;
    logic            hreq;
    logic            found;
    logic [IW-1:0]   win;
    logic [IW-1:0]   park_idx;
    logic [IW-1:0]   target;
    logic            start;
    arb_act_e        act;

    assign obs  = '{frame: bus_frame_i, ready: bus_ready_i};
    assign idle = bus_is_idle(obs);
    assign hv   = |gnt_q;

    always_comb begin
        hidx = '0;
        for (int i = 0; i < NREQ; i++)
            if (gnt_q[i]) hidx = IW'(i);
    end

    assign eff_req  = req_i & ~(ign & {NREQ{!bm_off_i}});
    assign hreq     = eff_req[hidx];
    assign park_idx = park_host_i ? '0 : last_q;
    assign target   = found ? win : park_idx;
    assign start    = bus_frame_i && hv && !off_q;

    busarb_select #(.N(NREQ), .IW(IW)) u_select (
        .req_i   (eff_req),
        .prio_i  (prio_i),
        .ptr_i   (ptr_q),
        .found_o (found),
        .win_o   (win)
    );

    busarb_bmwatch #(.N(NREQ), .LIMIT(IDLE_LIMIT), .IW(IW)) u_watch (
        .clk    (clk),
        .rst    (rst),
        .en_i   (!bm_off_i),
        .hv_i   (hv),
        .idx_i  (hidx),
        .hreq_i (hreq),
        .used_i (used_q),
        .idle_i (idle),
        .clr_i  (ign_clr_i),
        .ign_o  (ign)
    );

    always_comb begin
        act = ACT_HOLD;
        if (off_q)
            act = ACT_GAP;
        else if (!idle)
            act = ACT_HOLD;
        else if (hv && hreq && !used_q)
            act = ACT_HOLD;
        else if (hv && (hidx == target))
            act = found ? ACT_GRANT : ACT_HOLD;
        else if (hv)
            act = ACT_GAP;
        else
            act = found ? ACT_GRANT : ACT_PARK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q  <= arb_off_strap_i;
            gnt_q  <= '0;
            used_q <= 1'b0;
            last_q <= '0;
            ptr_q  <= IW'(NREQ - 1);
        end else begin
            unique case (act)
                ACT_GRANT: begin
                    gnt_q  <= {{(NREQ-1){1'b0}}, 1'b1} << target;
                    used_q <= 1'b0;
                    ptr_q  <= win;
                end
                ACT_PARK: begin
                    gnt_q  <= {{(NREQ-1){1'b0}}, 1'b1} << park_idx;
                    used_q <= 1'b0;
                end
                ACT_GAP: begin
                    gnt_q  <= '0;
                    used_q <= 1'b0;
                end
                default: ;
            endcase
            if (start) begin
                used_q <= 1'b1;
                last_q <= hidx;
            end
        end
    end

    assign gnt_o = gnt_q;
    assign ign_o = ign;
endmodule

// File: rtl/busarb_props.sv
module busarb_props #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] gnt,
    input logic [N-1:0] ign,
    input logic         frame,
    input logic         ready,
    input logic         bm_off,
    input logic         off
);
    p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (frame || ready) |=> $stable(gnt));

    p_disabled_r2: assert property (@(posedge clk) disable iff (rst)
        off |-> (gnt == '0));

    p_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (gnt != '0) |=> ((gnt == '0) || $stable(gnt)));

    p_no_new_flag_r11: assert property (@(posedge clk) disable iff (rst)
        bm_off |=> ((ign & ~$past(ign)) == '0));

    p_host_unflagged_r10: assert property (@(posedge clk) disable iff (rst)
        !ign[0]);
endmodule

bind busarb_top busarb_props #(.N(NREQ)) u_props (
    .clk    (clk),
    .rst    (rst),
    .gnt    (gnt_o),
    .ign    (ign_o),
    .frame  (bus_frame_i),
    .ready  (bus_ready_i),
    .bm_off (bm_off_i),
    .off    (off_q)
);

// File: tb/busarb_top_test.sv
module busarb_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int LIM = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0, prio = '0, clr = '0;
    logic         frame = 1'b0, ready = 1'b0, park = 1'b0, bmoff = 1'b0, strap = 1'b0;
    logic [N-1:0] gnt, ign;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference state
    logic [N-1:0] m_gnt, m_ign;
    logic m_used, m_off;
    int m_last, m_ptr, m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    busarb_top #(.NREQ(N), .IDLE_LIMIT(LIM)) uut (
        .clk(clk), .rst(rst), .req_i(req), .prio_i(prio),
        .bus_frame_i(frame), .bus_ready_i(ready), .park_host_i(park),
        .bm_off_i(bmoff), .arb_off_strap_i(strap), .ign_clr_i(clr),
        .gnt_o(gnt), .ign_o(ign)
    );

    function automatic int pick(logic [N-1:0] r, logic [N-1:0] p, int ptr);
        for (int k = 1; k <= N; k++)
            if (r[(ptr + k) % N] && p[(ptr + k) % N]) return (ptr + k) % N;
        for (int k = 1; k <= N; k++)
            if (r[(ptr + k) % N]) return (ptr + k) % N;
        return -1;
    endfunction

    task automatic model_edge();
        logic hv, idle, hreq, cnt_on;
        logic [N-1:0] eff, setv;
        int h, w, tgt;
        if (rst) begin
            m_gnt = '0; m_ign = '0; m_used = 0; m_last = 0;
            m_ptr = N - 1; m_cnt = 0; m_off = strap;
            return;
        end
        hv = |m_gnt;
        h = 0;
        for (int i = 0; i < N; i++) if (m_gnt[i]) h = i;
        idle = !frame && !ready;
        eff = req & ~(m_ign & {N{!bmoff}});
        hreq = eff[h];
        w = pick(eff, prio, m_ptr);
        tgt = (w >= 0) ? w : (park ? 0 : m_last);
        // broken initiator watch (R10)
        cnt_on = !bmoff && hv && h != 0 && hreq && !m_used && idle;
        setv = '0;
        if (cnt_on && m_cnt == LIM - 1) begin setv[h] = 1'b1; m_cnt = 0; end
        else if (cnt_on) m_cnt = m_cnt + 1;
        else m_cnt = 0;
        m_ign = (m_ign & ~clr) | setv;
        // decision
        if (m_off) begin m_gnt = '0; m_used = 0; end
        else if (!idle) begin end
        else if (hv && hreq && !m_used) begin end
        else if (hv && h == tgt) begin
            if (w >= 0) begin m_used = 0; m_ptr = w; end
        end
        else if (hv) begin m_gnt = '0; m_used = 0; end
        else begin
            m_gnt = '0; m_gnt[tgt] = 1'b1; m_used = 0;
            if (w >= 0) m_ptr = w;
        end
        if (frame && hv && !m_off) begin m_used = 1; m_last = h; end
    endtask

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: model updates on the edge, outputs compared mid-cycle
    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({tag, " grant"}, gnt, m_gnt);
        chk({tag, " flags"}, ign, m_ign);
    endtask

    task automatic do_reset(logic s);
        rst = 1'b1; strap = s; req = '0; frame = 0; ready = 0; clr = '0;
        step("R1");
        step("R1");
        chk("R1 reset grant", gnt, '0);
        chk("R1 reset flags", ign, '0);
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R2: strapped off
        do_reset(1'b1);
        for (int i = 0; i < 40; i++) begin
            req = N'($urandom); frame = ($urandom % 5 == 0);
            step("R2");
            chk("R2 no grant while disabled", gnt, '0);
        end
        do_reset(1'b0);
        // R7: park on last user, host after reset
        prio = '0; park = 0;
        step("R7");
        chk("R7 park after reset", gnt, 4'b0001);
        // R5 and R4: high-priority index 2 wins over 1 and 3, with a gap
        prio = 4'b0100; req = 4'b1110;
        step("R4");
        chk("R4 handover gap", gnt, 4'b0000);
        step("R5");
        chk("R5 high group wins", gnt, 4'b0100);
        // R9/R10: holder 2 never starts
        for (int i = 0; i < LIM - 1; i++) step("R9");
        chk("R9 holder keeps grant", gnt, 4'b0100);
        chk("R10 no flag before window ends", ign, 4'b0000);
        step("R10");
        chk("R10 flag after 16 idle cycles", ign, 4'b0100);
        // R6: ignored 2 skipped, rotation after 2 gives 3
        step("R6");
        chk("R6 gap before next owner", gnt, 4'b0000);
        step("R6");
        chk("R6 rotation picks index 3", gnt, 4'b1000);
        // R9 start credited to 3, then R7 parking keeps it
        frame = 1; step("R9");
        frame = 0; req = '0; step("R7");
        step("R7");
        chk("R7 parked on last user", gnt, 4'b1000);
        // R8: park on host
        park = 1; step("R8");
        chk("R8 gap before host", gnt, 4'b0000);
        step("R8");
        chk("R8 parked on host", gnt, 4'b0001);
        // R11: flagged 2 is honoured again when detection is off
        bmoff = 1; req = 4'b0100; step("R11"); step("R11");
        chk("R11 flagged requester served", gnt, 4'b0100);
        for (int i = 0; i < 2 * LIM; i++) step("R11");
        chk("R11 no new flags", ign, 4'b0100);
        // R12: clear pulse
        clr = 4'b0100; step("R12");
        clr = '0;
        chk("R12 flag cleared", ign, 4'b0000);
        bmoff = 0; req = '0; park = 0;
        // random traffic against the reference model (R3, R6, R10)
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 4 == 0) req = N'($urandom);
            frame = ($urandom % 6 == 0);
            ready = ($urandom % 8 == 0);
            clr = ($urandom % 25 == 0) ? N'($urandom) : '0;
            if (i % 97 == 0) prio = N'($urandom);
            if (i % 211 == 0) park = $urandom % 2;
            if (i % 150 == 0) bmoff = ($urandom % 5 == 0);
            step("R3");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule